// File: doc/BRIEF.md
# Weighted Uplink/Downlink Code-Block Scheduler

This block decides which of two traffic classes may use one shared host-interface path: the uplink (decode) request stream or the downlink (encode) request stream. The unit of scheduling is the code block. A grant, once given, stays with its class until that class reports the end of the block with a done pulse. How many cycles the block takes has no effect on the shares.

Each class has an 8-bit weight, and one weight step is worth three code blocks. While both classes are requesting (the congested case), each class draws on a credit counter that is loaded with its weight times three and loses one credit per finished block. A class with credit left is preferred over a class with none. Both counters reload when both have run dry, and also whenever neither class is requesting. A class that requests alone is served whatever its credit. A weight of zero therefore gives that class the path only while the other class is idle. When both classes are eligible on equal terms, the class that was not served last wins.

Top module: `cbsched_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant_o` is 2'b00.
- R2: `grant_o` has at most one bit set. Bit 0 means uplink and bit 1 means downlink. A grant appears in the cycle after a cycle with no grant held in which its class was requesting.
- R3: A grant stays unchanged until the owning class pulses its done input. The other class's done pulse has no effect. The grant drops to 2'b00 in the cycle after the owner's done.
- R4: When exactly one class is requesting in a cycle with no grant held, that class is granted, even with zero credit.
- R5: Each class's credit is loaded with weight×3 and falls by one per completed block of that class. While both classes contend, a class with credit left beats a class with none.
- R6: A class with weight 0 is never granted while the other class is also requesting.
- R7: When both classes contend and both have credit, or both have none, the grant goes to the class not granted most recently. After reset, downlink counts as the most recent one.
- R8: Both credits reload when both have reached zero, and in any cycle with no grant held and no class requesting.
- R9: Credit is counted per code block. A block held for one cycle costs the same credit as a block held for several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ul_req_i | input | 1 | Uplink has a code block pending |
| dl_req_i | input | 1 | Downlink has a code block pending |
| ul_done_i | input | 1 | Uplink code block finished (one-cycle pulse) |
| dl_done_i | input | 1 | Downlink code block finished (one-cycle pulse) |
| ul_weight_i | input | 8 | Uplink weight, three blocks per step |
| dl_weight_i | input | 8 | Downlink weight, three blocks per step |
| grant_o | output | 2 | One-hot grant: bit 0 uplink, bit 1 downlink |

## Verification
The bench drives a long congested run with weights 1 and 2 and uses blocks of different lengths. A design that counted cycles instead of blocks, or that loaded weight×1 instead of weight×3, would move the point where uplink falls silent and downlink runs alone. The run continues across the point where both credits run out. There a wrong tie rule would serve downlink twice in a row. A design missing the reload when both are dry would deadlock or starve both classes. Directed cases check several further faults:
- A foreign done pulse during a grant, which a sloppy release would act on.
- A zero-weight class under contention, which must lose every time but still be served alone.
- An idle gap after a weight change, which only a design that reloads on idle would honour, alternating at once instead of draining the stale downlink credit.

// File: rtl/cbsched_pkg.sv
package cbsched_pkg;

    typedef enum logic {
        CLS_UL = 1'b0,
        CLS_DL = 1'b1
    } cls_e;

    localparam int unsigned NUM_CLS = 2;

    typedef struct packed {
        logic busy;
        cls_e owner;
        cls_e last;
    } arb_st_t;

endpackage

// File: rtl/cbsched_credit.sv
module cbsched_credit #(
    parameter int unsigned WW = 8,
    parameter int unsigned CW = WW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] weight_i,
    input  logic          reload_i,
    input  logic          consume_i,
    output logic [CW-1:0] eff_o,
    output logic          zero_o
);

    typedef struct packed {
        logic [CW-1:0] cred;
    } cred_st_t;

    cred_st_t st_d, st_q;
    logic [CW-1:0] full;

    always_comb begin
        full  = CW'({weight_i, 1'b0}) + CW'(weight_i);
        st_d  = st_q;
        eff_o = reload_i ? full : st_q.cred;
        if (reload_i) begin
            st_d.cred = full;
        end else if (consume_i && (st_q.cred != '0)) begin
            st_d.cred = st_q.cred - CW'(1);
        end
        zero_o = (st_q.cred == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: one finished block removes exactly one credit
    a_r9_one_per_block: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !reload_i && !zero_o) |=> (st_q.cred == $past(st_q.cred) - CW'(1)));

    // R5: reload always lands on weight times three
    a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && $stable(weight_i)) |=> (st_q.cred == CW'({weight_i, 1'b0}) + CW'(weight_i)));

endmodule

// File: rtl/cbsched_pick.sv
module cbsched_pick
    import cbsched_pkg::*;
(
    input  logic ul_req_i,
    input  logic dl_req_i,
    input  logic ul_has_i,
    input  logic dl_has_i,
    input  cls_e last_i,
    output logic valid_o,
    output cls_e pick_o
);

    always_comb begin
        valid_o = ul_req_i || dl_req_i;
        pick_o  = CLS_UL;
        if (ul_req_i && !dl_req_i) begin
            pick_o = CLS_UL;
        end else if (dl_req_i && !ul_req_i) begin
            pick_o = CLS_DL;
        end else if (ul_has_i && !dl_has_i) begin
            pick_o = CLS_UL;
        end else if (dl_has_i && !ul_has_i) begin
            pick_o = CLS_DL;
        end else begin
            pick_o = (last_i == CLS_UL) ? CLS_DL : CLS_UL;
        end
    end

endmodule

// File: rtl/cbsched_top.sv
module cbsched_top
    import cbsched_pkg::*;
#(
    parameter int unsigned WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ul_req_i,
    input  logic          dl_req_i,
    input  logic          ul_done_i,
    input  logic          dl_done_i,
    input  logic [WW-1:0] ul_weight_i,
    input  logic [WW-1:0] dl_weight_i,
    output logic [1:0]    grant_o
);

    localparam int unsigned CW = WW + 2;

    arb_st_t st_d, st_q;

    logic [NUM_CLS-1:0]   req;
    logic [NUM_CLS-1:0]   done;
    logic [NUM_CLS-1:0]   consume;
    logic [NUM_CLS-1:0]   zero;
    logic [NUM_CLS-1:0]   has;
    logic [WW-1:0]        weight [NUM_CLS];
    logic [CW-1:0]        eff    [NUM_CLS];
    logic                 reload;
    logic                 pick_valid;
    cls_e                 pick;

    assign req       = {dl_req_i, ul_req_i};
    assign done      = {dl_done_i, ul_done_i};
    assign weight[0] = ul_weight_i;
    assign weight[1] = dl_weight_i;

    assign reload = !st_q.busy && ((zero[0] && zero[1]) || (req == '0));

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign consume[c] = st_q.busy && (st_q.owner == cls_e'(c)) && done[c];
        assign has[c]     = (eff[c] != '0);

        cbsched_credit #(
            .WW (WW),
            .CW (CW)
        ) i_credit (
            .clk       (clk),
            .rst_n     (rst_n),
            .weight_i  (weight[c]),
            .reload_i  (reload),
            .consume_i (consume[c]),
            .eff_o     (eff[c]),
            .zero_o    (zero[c])
        );
    end

    cbsched_pick i_pick (
        .ul_req_i (ul_req_i),
        .dl_req_i (dl_req_i),
        .ul_has_i (has[0]),
        .dl_has_i (has[1]),
        .last_i   (st_q.last),
        .valid_o  (pick_valid),
        .pick_o   (pick)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (done[st_q.owner]) begin
                st_d.busy = 1'b0;
            end
        end else if (pick_valid) begin
            st_d.busy  = 1'b1;
            st_d.owner = pick;
            st_d.last  = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, owner: CLS_UL, last: CLS_DL};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.busy ? ((st_q.owner == CLS_DL) ? 2'b10 : 2'b01) : 2'b00;

    // R2: never more than one class on the path
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: a new grant only follows a request of that class
    a_r2_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == 2'b00) |=> ((!grant_o[0] || $past(ul_req_i)) && (!grant_o[1] || $past(dl_req_i))));

    // R3: grant held until its owner finishes
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o[0] && !ul_done_i) || (grant_o[1] && !dl_done_i)) |=> $stable(grant_o));

    // R3: owner's done releases the path next cycle
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o[0] && ul_done_i) || (grant_o[1] && dl_done_i)) |=> (grant_o == 2'b00));

    // R4: a lone requester is served
    a_r4_lone_ul: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o == 2'b00) && ul_req_i && !dl_req_i) |=> (grant_o == 2'b01));

    // R6: zero credit loses against a class with credit
    a_r6_no_credit_loses: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o == 2'b00) && ul_req_i && dl_req_i && !has[0] && has[1]) |=> (grant_o == 2'b10));

endmodule

// File: tb/test_cbsched_top.sv
module test_cbsched_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ul_req = 1'b0, dl_req = 1'b0;
    logic       ul_done = 1'b0, dl_done = 1'b0;
    logic [7:0] ul_w = 8'd1, dl_w = 8'd2;
    logic [1:0] grant;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    cbsched_top i_cbsched_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .ul_req_i    (ul_req),
        .dl_req_i    (dl_req),
        .ul_done_i   (ul_done),
        .dl_done_i   (dl_done),
        .ul_weight_i (ul_w),
        .dl_weight_i (dl_w),
        .grant_o     (grant)
    );

    // {ul_req, dl_req, hold length[3:0], expected grant[1:0]}; weights 1 and 2
    localparam logic [7:0] TBL [15] = '{
        {2'b11, 4'd2, 2'b01}, {2'b11, 4'd3, 2'b10}, {2'b11, 4'd1, 2'b01},
        {2'b11, 4'd4, 2'b10}, {2'b11, 4'd2, 2'b01}, {2'b11, 4'd1, 2'b10},
        {2'b11, 4'd5, 2'b10}, {2'b11, 4'd2, 2'b10}, {2'b11, 4'd1, 2'b10},
        {2'b11, 4'd3, 2'b01}, {2'b10, 4'd2, 2'b01}, {2'b01, 4'd1, 2'b10},
        {2'b11, 4'd2, 2'b01}, {2'b11, 4'd3, 2'b10}, {2'b11, 4'd1, 2'b10}
    };

    task automatic check(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // waits for a grant, checks owner, holds len cycles, optional foreign done, then owner done
    task automatic run_block(input logic [1:0] exp, input int len, input string tag, input bit foreign);
        for (int i = 0; i < 4 && grant == 2'b00; i++) @(negedge clk);
        check(grant == exp, tag, grant, exp);
        for (int i = 1; i < len; i++) @(negedge clk);
        if (foreign) begin
            ul_done = grant[1];
            dl_done = grant[0];
            @(negedge clk);
            ul_done = 1'b0;
            dl_done = 1'b0;
            check(grant == exp, "R3 foreign done ignored", grant, exp);
        end
        ul_done = grant[0];
        dl_done = grant[1];
        @(negedge clk);
        ul_done = 1'b0;
        dl_done = 1'b0;
        check(grant == 2'b00, "R3 release after done", grant, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ul_req = 1'b0;
        dl_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(grant == 2'b00, "R1 in reset", grant, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant == 2'b00, "R1 after reset", grant, 2'b00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: grant actual %b expected progress", grant);
            finish_run();
        end
    end

    initial begin
        do_reset();

        // R5 R7 R9 R4: congested run across a double-empty reload, mixed block lengths
        for (int k = 0; k < 15; k++) begin
            ul_req = TBL[k][7];
            dl_req = TBL[k][6];
            run_block(TBL[k][1:0], int'(TBL[k][5:2]), $sformatf("R5/R7 entry %0d", k), 1'b0);
        end

        // R3: the other class's done pulse must not end the block
        ul_req = 1'b1;
        dl_req = 1'b1;
        @(negedge clk);
        run_block(grant == 2'b00 ? 2'b01 : grant, 3, "R3 owner kept", 1'b1);

        // R6: zero weight loses every contended block, then served alone (R4)
        ul_w = 8'd0;
        dl_w = 8'd1;
        do_reset();
        ul_req = 1'b1;
        dl_req = 1'b1;
        for (int k = 0; k < 4; k++) run_block(2'b10, 2, "R6 zero weight loses", 1'b0);
        dl_req = 1'b0;
        run_block(2'b01, 1, "R4 zero weight served alone", 1'b0);

        // R8: idle gap reloads with new weights, so contention alternates at once
        ul_w = 8'd1;
        dl_w = 8'd1;
        ul_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ul_req = 1'b1;
        dl_req = 1'b1;
        run_block(2'b10, 1, "R8 reload on idle first", 1'b0);
        run_block(2'b01, 2, "R8 reload on idle second", 1'b0);

        ul_req = 1'b0;
        dl_req = 1'b0;
        @(negedge clk);
        check(grant == 2'b00, "R2 no request no grant", grant, 2'b00);
        finish_run();
    end

endmodule